// File: doc/BRIEF.md
# Weighted Switching Activity Monitor

This block measures the switching activity that a single launch clock causes in a circuit under test. It receives two node-value vectors, one sampled before the launch edge and one after it. A node that differs between the two counts as a toggle. Each toggle is weighted by one plus that node's fanout, and the weighted toggles are summed into a per-test activity figure. The fanout of every node is fixed at elaboration by a packed parameter table.

Nodes are visited serially, one node per clock, so the arithmetic needs only a single adder. When the scan finishes, the per-test sum is held until a commit pulse hands it to the statistics stage. That stage keeps the largest per-test value seen and the running total and test count of the set. The reader forms the average as total divided by count. On each commit the block also issues an accept or reject verdict by comparing the sum against a programmable limit. A clear input starts a new test set.

Top module: `wsa_monitor`

## Requirements
- R1: After reset, `busy`, `sum_valid`, `verdict_valid`, `reject`, `peak`, `total` and `count` are all zero.
- R2: The per-test sum equals the sum, over every node i with `pre_vec[i] != post_vec[i]`, of 1 + fanout(i). Fanout(i) is the field at bits `[i*FAN_W +: FAN_W]` of `FANOUT_TABLE`.
- R3: A `start` taken while idle or holding a result makes `busy` high for exactly N_NODES cycles. `sum_valid` rises in the same cycle in which `busy` falls.
- R4: A `start` that arrives while `busy` is high is ignored: the scan in progress completes with its own vectors.
- R5: A `test_done` while `sum_valid` is high commits the sum. `peak` becomes the larger of itself and the sum, `total` gains the sum, `count` gains one, and `sum_valid` drops. A `test_done` without `sum_valid` changes nothing.
- R6: The cycle after a commit, `verdict_valid` is high for exactly one cycle. At that time `reject` is 1 when the committed sum is strictly greater than `threshold`, and 0 otherwise, so a sum equal to the threshold is accepted.
- R7: `clr` zeroes `peak`, `total` and `count`. When `clr` and a commit fall in the same cycle, the clear wins and the three statistics end at zero, while the verdict for that test is still issued.
- R8: Once `count` holds its all-ones value, further commits leave `count` and `total` unchanged, so the pair stays a consistent average, while `peak` still tracks the maximum.
- R9: When the two vectors are identical, the committed sum is zero and the test is accepted for any threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Clear peak, total and count |
| start | input | 1 | Latch the vectors and begin a scan |
| pre_vec | input | N_NODES | Node values before the launch edge |
| post_vec | input | N_NODES | Node values after the launch edge |
| test_done | input | 1 | Commit the held per-test sum |
| threshold | input | SUM_W | Largest accepted activity |
| busy | output | 1 | Scan in progress |
| sum_valid | output | 1 | Per-test sum ready and not yet committed |
| test_sum | output | SUM_W | Per-test weighted activity |
| verdict_valid | output | 1 | One-cycle pulse after a commit |
| reject | output | 1 | Committed sum exceeded the threshold |
| peak | output | SUM_W | Largest committed sum since clear |
| total | output | TOT_W | Sum of committed values since clear |
| count | output | COUNT_W | Number of committed tests since clear |

## Verification
Clear and commit can land on the same edge. In that case the bench expects the statistics to read zero afterwards while a verdict for the coinciding test still appears. Every eleventh test of the sweep raises `clr` together with `test_done`. Other tests raise `clr` on an edge of its own. The bench's running model of peak, total and count follows the same priority, and the registers are compared against that model after every commit. The sweep covers all 256 toggle masks of an eight-node configuration with a three-bit count, so saturation of the count is reached many times between clears.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

  typedef enum logic [1:0] {
    SCAN_IDLE  = 2'd0,
    SCAN_RUN   = 2'd1,
    SCAN_READY = 2'd2
  } scan_state_t;

  // Width needed to hold values 0..max_val
  function automatic int width_for(input longint max_val);
    int w;
    w = 1;
    while ((longint'(1) << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/wsa_scanner.sv
module wsa_scanner
  import wsa_pkg::*;
#(
  parameter int N_NODES = 8,
  parameter int FAN_W   = 4,
  parameter int SUM_W   = 8,
  parameter logic [N_NODES*FAN_W-1:0] FANOUT_TABLE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             consume,
  input  logic [N_NODES-1:0] pre_vec,
  input  logic [N_NODES-1:0] post_vec,
  output logic             start_ok,
  output logic             busy,
  output logic             sum_valid,
  output logic [SUM_W-1:0] sum
);

  localparam int IDX_W = (N_NODES > 1) ? $clog2(N_NODES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_NODES - 1);

  // Weight of a node: one plus its fanout
  function automatic logic [SUM_W-1:0] node_weight(input logic [FAN_W-1:0] fo);
    return SUM_W'(fo) + SUM_W'(1);
  endfunction

  logic [SUM_W-1:0] weight [N_NODES];

  for (genvar g = 0; g < N_NODES; g++) begin : g_weight
    assign weight[g] = node_weight(FANOUT_TABLE[g*FAN_W +: FAN_W]);
  end

  scan_state_t        state_q;
  logic [N_NODES-1:0] toggles_q;
  logic [IDX_W-1:0]   idx_q;
  logic [SUM_W-1:0]   acc_q;
  logic [SUM_W-1:0]   step_add;
  logic               last_step;

  assign start_ok  = start && (state_q != SCAN_RUN);
  assign busy      = (state_q == SCAN_RUN);
  assign sum_valid = (state_q == SCAN_READY);
  assign sum       = acc_q;
  assign step_add  = toggles_q[idx_q] ? weight[idx_q] : '0;
  assign last_step = (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SCAN_IDLE;
      toggles_q <= '0;
      idx_q     <= '0;
      acc_q     <= '0;
    end else begin
      case (state_q)
        SCAN_RUN: begin
          acc_q <= acc_q + step_add;
          idx_q <= idx_q + IDX_W'(1);
          if (last_step) begin
            state_q <= SCAN_READY;
          end
        end
        default: begin
          if (start_ok) begin
            toggles_q <= pre_vec ^ post_vec;
            idx_q     <= '0;
            acc_q     <= '0;
            state_q   <= SCAN_RUN;
          end else if (consume && state_q == SCAN_READY) begin
            state_q <= SCAN_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/wsa_stats.sv
module wsa_stats #(
  parameter int SUM_W   = 8,
  parameter int COUNT_W = 16,
  parameter int TOT_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               commit,
  input  logic [SUM_W-1:0]   sum,
  output logic               count_full,
  output logic [SUM_W-1:0]   peak,
  output logic [TOT_W-1:0]   total,
  output logic [COUNT_W-1:0] count
);

  function automatic logic [SUM_W-1:0] larger(input logic [SUM_W-1:0] a,
                                              input logic [SUM_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign count_full = &count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak  <= '0;
      total <= '0;
      count <= '0;
    end else if (clr) begin
      peak  <= '0;
      total <= '0;
      count <= '0;
    end else if (commit) begin
      peak <= larger(peak, sum);
      if (!count_full) begin
        total <= total + TOT_W'(sum);
        count <= count + COUNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/wsa_judge.sv
module wsa_judge #(
  parameter int SUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [SUM_W-1:0] sum,
  input  logic [SUM_W-1:0] threshold,
  output logic             verdict_valid,
  output logic             reject
);

  function automatic logic over_limit(input logic [SUM_W-1:0] s,
                                      input logic [SUM_W-1:0] lim);
    return s > lim;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_valid <= 1'b0;
      reject        <= 1'b0;
    end else begin
      verdict_valid <= commit;
      if (commit) begin
        reject <= over_limit(sum, threshold);
      end
    end
  end

endmodule

// File: rtl/wsa_monitor.sv
module wsa_monitor
  import wsa_pkg::*;
#(
  parameter int N_NODES = 8,
  parameter int FAN_W   = 4,
  parameter int COUNT_W = 16,
  parameter logic [N_NODES*FAN_W-1:0] FANOUT_TABLE = 32'hF30D_A741,
  localparam int SUM_W = width_for(longint'(N_NODES) * (longint'(1) << FAN_W)),
  localparam int TOT_W = SUM_W + COUNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               start,
  input  logic [N_NODES-1:0] pre_vec,
  input  logic [N_NODES-1:0] post_vec,
  input  logic               test_done,
  input  logic [SUM_W-1:0]   threshold,
  output logic               busy,
  output logic               sum_valid,
  output logic [SUM_W-1:0]   test_sum,
  output logic               verdict_valid,
  output logic               reject,
  output logic [SUM_W-1:0]   peak,
  output logic [TOT_W-1:0]   total,
  output logic [COUNT_W-1:0] count
);

  // Named internal events for the checker
  logic start_ok;
  logic commit;
  logic count_full;

  assign commit = test_done && sum_valid;

  wsa_scanner #(
    .N_NODES      (N_NODES),
    .FAN_W        (FAN_W),
    .SUM_W        (SUM_W),
    .FANOUT_TABLE (FANOUT_TABLE)
  ) u_scanner (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .consume   (commit),
    .pre_vec   (pre_vec),
    .post_vec  (post_vec),
    .start_ok  (start_ok),
    .busy      (busy),
    .sum_valid (sum_valid),
    .sum       (test_sum)
  );

  wsa_stats #(
    .SUM_W   (SUM_W),
    .COUNT_W (COUNT_W),
    .TOT_W   (TOT_W)
  ) u_stats (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .commit     (commit),
    .sum        (test_sum),
    .count_full (count_full),
    .peak       (peak),
    .total      (total),
    .count      (count)
  );

  wsa_judge #(
    .SUM_W (SUM_W)
  ) u_judge (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit        (commit),
    .sum           (test_sum),
    .threshold     (threshold),
    .verdict_valid (verdict_valid),
    .reject        (reject)
  );

endmodule

// File: rtl/wsa_monitor_chk.sv
module wsa_monitor_chk #(
  parameter int SUM_W   = 8,
  parameter int COUNT_W = 16,
  parameter int TOT_W   = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               start_ok,
  input logic               commit,
  input logic               count_full,
  input logic               busy,
  input logic               sum_valid,
  input logic               verdict_valid,
  input logic [SUM_W-1:0]   peak,
  input logic [TOT_W-1:0]   total,
  input logic [COUNT_W-1:0] count
);

  assert_scan_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sum_valid);

  assert_scan_begin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy && !sum_valid);

  assert_commit_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !clr && !count_full) |=> (count == $past(count) + 1'b1));

  assert_commit_consumes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !start_ok) |=> !sum_valid);

  assert_peak_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (peak >= $past(peak)));

  assert_verdict_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $past(commit));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && total == '0 && peak == '0));

  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !clr && count_full) |=> ($stable(count) && $stable(total)));

endmodule

bind wsa_monitor wsa_monitor_chk #(
  .SUM_W   (SUM_W),
  .COUNT_W (COUNT_W),
  .TOT_W   (TOT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clr           (clr),
  .start_ok      (start_ok),
  .commit        (commit),
  .count_full    (count_full),
  .busy          (busy),
  .sum_valid     (sum_valid),
  .verdict_valid (verdict_valid),
  .peak          (peak),
  .total         (total),
  .count         (count)
);

// File: tb/test_wsa_monitor.sv
`timescale 1ns/1ps
module test_wsa_monitor;

  localparam int N   = 8;
  localparam int FW  = 4;
  localparam int CW  = 3;
  localparam logic [N*FW-1:0] TABLE = 32'hF30D_A741;
  localparam int SW  = 8;
  localparam int TW  = SW + CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  pre_vec = '0;
  logic [N-1:0]  post_vec = '0;
  logic          test_done = 1'b0;
  logic [SW-1:0] threshold = '0;
  logic          busy, sum_valid, verdict_valid, reject;
  logic [SW-1:0] test_sum, peak;
  logic [TW-1:0] total;
  logic [CW-1:0] count;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wsa_monitor #(
    .N_NODES      (N),
    .FAN_W        (FW),
    .COUNT_W      (CW),
    .FANOUT_TABLE (TABLE)
  ) i_wsa_monitor (
    .clk, .rst_n, .clr, .start, .pre_vec, .post_vec, .test_done,
    .threshold, .busy, .sum_valid, .test_sum, .verdict_valid, .reject,
    .peak, .total, .count
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected activity: add (fanout + 1) for every differing node
  function automatic int expect_sum(input logic [N-1:0] a, input logic [N-1:0] b);
    int s = 0;
    for (int k = 0; k < N; k++)
      if (a[k] !== b[k]) s += int'(TABLE[k*FW +: FW]) + 1;
    return s;
  endfunction

  int m_peak = 0, m_total = 0, m_cnt = 0;

  task automatic run_test(input logic [N-1:0] a, input logic [N-1:0] b,
                          input int thr, input bit with_clr, input bit poke);
    int es;
    es = expect_sum(a, b);
    @(negedge clk);
    pre_vec = a; post_vec = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 busy after start", busy, 1);
    chk("R3 no sum during scan", sum_valid, 0);
    if (poke) begin
      // R4: a second start mid-scan with other vectors must not disturb it
      start = 1'b1; pre_vec = ~a; post_vec = a;
      @(negedge clk);
      start = 1'b0;
      repeat (N - 2) @(negedge clk);
    end else begin
      repeat (N - 1) @(negedge clk);
    end
    chk("R3 busy for N cycles", busy, 1);
    @(negedge clk);
    chk("R3 busy falls", busy, 0);
    chk("R3 sum_valid rises", sum_valid, 1);
    chk(poke ? "R4 sum kept" : "R2 sum", test_sum, es);
    if (a == b) chk("R9 zero sum", test_sum, 0);
    threshold = SW'(thr);
    test_done = 1'b1;
    clr = with_clr;
    @(negedge clk);
    test_done = 1'b0; clr = 1'b0;
    if (with_clr) begin
      m_peak = 0; m_total = 0; m_cnt = 0;
    end else begin
      if (es > m_peak) m_peak = es;
      if (m_cnt < (1 << CW) - 1) begin
        m_total += es; m_cnt++;
      end
    end
    chk("R6 verdict pulse", verdict_valid, 1);
    chk("R6 reject", reject, (es > thr) ? 1 : 0);
    chk("R5 sum consumed", sum_valid, 0);
    chk(with_clr ? "R7 peak" : "R5 peak", peak, m_peak);
    chk(m_cnt == 7 ? "R8 total" : "R5 total", total, m_total);
    chk(m_cnt == 7 ? "R8 count" : "R5 count", count, m_cnt);
    // R5: a stray commit without a held sum changes nothing
    test_done = 1'b1;
    @(negedge clk);
    test_done = 1'b0;
    chk("R6 single pulse", verdict_valid, 0);
    chk("R5 stray count", count, m_cnt);
    chk("R5 stray total", total, m_total);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 sum_valid", sum_valid, 0);
    chk("R1 verdict", verdict_valid, 0);
    chk("R1 reject", reject, 0);
    chk("R1 peak", peak, 0);
    chk("R1 total", total, 0);
    chk("R1 count", count, 0);
    rst_n = 1'b1;
    // Identical vectors: accepted even at threshold zero (R9)
    run_test(8'h5A, 8'h5A, 0, 1'b0, 1'b0);
    chk("R9 accepted", reject, 0);
    // Equality with the threshold is accepted (R6)
    run_test(8'h00, 8'h01, 2, 1'b0, 1'b0);
    chk("R6 equal accepted", reject, 0);
    for (int m = 0; m < 256; m++) begin
      logic [N-1:0] base;
      bit wc;
      base = N'((m * 37 + 11) & 8'hFF);
      wc = (m % 11 == 10);
      if (m % 9 == 8) begin
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        m_peak = 0; m_total = 0; m_cnt = 0;
        chk("R7 clear count", count, 0);
        chk("R7 clear peak", peak, 0);
      end
      run_test(base, base ^ N'(m), (m * 13) % 140, wc, (m % 7 == 3));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule